// File: doc/BRIEF.md
# Byte-Serial Double-Error-Correcting BCH(63,51) Decoder

This block takes a 63-bit BCH(63,51) codeword from a byte-wide memory port. It repairs up to two flipped bits and returns the 51 message bits. A word arrives as eight bytes on a valid/ready stream. The first byte carries positions 63 down to 56, with the most significant bit holding the highest position. Position 63 is padding that fills out the eighth byte. The decoder folds each byte into four GF(2^6) syndromes as it arrives. GF(2^6) is built on x^6 + x + 1.

Once the last byte is in, a two-step inversionless Berlekamp-Massey unit forms a degree-two error locator. An eight-position Chien search then walks the word over eight cycles, from the top byte down, and records every root. A final cycle compares the root count with the locator degree. It then emits one of three results: the word untouched, the corrected data, or the received data marked as uncorrectable.

The decoder handles one word at a time. `in_ready` is high only while a word is being loaded. There is one exception: in the cycle the finished result is taken (`out_valid` and `out_ready` both high), `in_ready` is also high, so the first byte of the next word can be accepted in that same cycle. The result stays on the output, unchanged, for as long as `out_ready` is held low.

Top module: `bch_dec63`

## Requirements
- R1: Each word is eight accepted bytes. Byte k (k = 0..7) carries positions 63-8k down to 56-8k, with bit 7 holding the highest of them. Position 63 (bit 7 of the first byte) is padding, and its value never changes any output.
- R2: The decoder forms the syndromes S_i = sum of r_j·α^(i·j) for i = 1..4 over GF(2^6), with field polynomial x^6 + x + 1 and α = x. The even syndromes always equal the squares of the odd ones: S2 = S1^2 and S4 = S2^2.
- R3: When all four syndromes are zero, `out_data[50:0]` equals received positions 62..12, and both flags are clear.
- R4: A single flipped bit at any position 0..62 is repaired. `out_data` holds the original message, `out_corrected` is 1 and `out_uncorrectable` is 0. This also holds when the flip is in parity positions 11..0.
- R5: Any two flipped bits among positions 0..62 are repaired, with `out_corrected` 1 and `out_uncorrectable` 0.
- R6: When no pattern of at most two errors explains the syndromes, the word is declared uncorrectable. This is the case when the locator degree is zero, or when the number of Chien roots differs from the degree. The result is then `out_uncorrectable` 1, `out_corrected` 0, and `out_data` equal to the received positions 62..12.
- R7: `out_corrected` and `out_uncorrectable` are never both 1 while `out_valid` is high.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` and both flags hold their values.
- R9: `in_ready` is 1 after reset. It is 0 from the edge that accepts the eighth byte until the result is taken. In the cycle `out_valid` and `out_ready` are both 1, `in_ready` is 1, and a byte offered there is taken as byte 0 of the next word.
- R10: `out_valid` rises on the eleventh rising clock edge after the edge that accepts the eighth byte of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A codeword byte is offered |
| in_ready | output | 1 | The decoder takes the offered byte at this edge |
| in_data | input | 8 | Codeword byte, highest positions first |
| out_valid | output | 1 | A decoded result is presented |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_data | output | 51 | Message bits, codeword positions 62..12 |
| out_corrected | output | 1 | One or two bits were repaired |
| out_uncorrectable | output | 1 | The error pattern exceeds two bits; the data is the raw received bits |

## Verification
Two functions can fall in the same cycle: handing over a finished result and accepting the first byte of the next word. The bench provokes this on alternate and random words. It raises `out_ready` and `in_valid` together while the result is presented, and checks that `in_ready` is high in that cycle. The overlap is then judged by whether the next word, which is missing no byte, decodes to its expected message, flags and latency. Those expected values come from a bench reference that searches all one-bit and two-bit error patterns for one matching the received syndromes.

// File: rtl/bch_pkg.sv
`timescale 1ns/1ps
package bch_pkg;
  localparam int GF_M      = 6;
  localparam int GF_N      = 63;
  localparam int BYTE_W    = 8;
  localparam int N_BEATS   = 8;
  localparam int PAR_W     = 12;
  localparam int DATA_W    = GF_N - PAR_W;
  localparam int N_SYN     = 4;
  localparam int LOC_TERMS = 3;
  localparam int N_ITER    = 2;
  localparam int CNT_W     = $clog2(N_BEATS);
  localparam logic [GF_M-1:0] GF_RED = 6'b000011;

  typedef logic [GF_M-1:0] gf_t;
  typedef enum logic [2:0] {ST_LOAD, ST_KEY, ST_SRCH, ST_FIN, ST_OUT} dec_state_e;

  function automatic gf_t gf_mul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[GF_M-2:0], 1'b0} ^ (sh[GF_M-1] ? GF_RED : '0);
    end
    return acc;
  endfunction

  function automatic gf_t gf_pow(int e);
    gf_t v;
    int  r;
    v = gf_t'(1);
    r = e % GF_N;
    for (int i = 0; i < r; i++) v = gf_mul(v, gf_t'(2));
    return v;
  endfunction
endpackage

// File: rtl/bch_syndrome.sv
`timescale 1ns/1ps
module bch_syndrome
  import bch_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    first,
  input  logic [BYTE_W-1:0]       byte_in,
  output logic [N_SYN*GF_M-1:0]   syn_o
);
  for (genvar gi = 1; gi <= N_SYN; gi++) begin : g_syn
    localparam gf_t STEP = gf_pow(gi * BYTE_W);
    gf_t s_q;
    gf_t term;

    always_comb begin
      term = '0;
      for (int k = 0; k < BYTE_W; k++)
        if (byte_in[k]) term = term ^ gf_pow(gi * k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    s_q <= '0;
      else if (beat) s_q <= (first ? gf_t'(0) : gf_mul(s_q, STEP)) ^ term;
    end

    assign syn_o[(gi-1)*GF_M +: GF_M] = s_q;
  end

  AST_SYN_EVEN_S2: assert property (@(posedge clk) disable iff (!rst_n) syn_o[GF_M +: GF_M] == gf_mul(syn_o[0 +: GF_M], syn_o[0 +: GF_M])); // R2
  AST_SYN_EVEN_S4: assert property (@(posedge clk) disable iff (!rst_n) syn_o[3*GF_M +: GF_M] == gf_mul(syn_o[GF_M +: GF_M], syn_o[GF_M +: GF_M])); // R2
endmodule

// File: rtl/bch_locator.sv
`timescale 1ns/1ps
module bch_locator
  import bch_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  step,
  input  logic [N_SYN*GF_M-1:0] syn_i,
  output gf_t                   lam0_o,
  output gf_t                   lam1_o,
  output gf_t                   lam2_o
);
  gf_t syn_w [N_SYN];
  gf_t lam_q [LOC_TERMS];
  gf_t bb_q  [LOC_TERMS-1];
  gf_t gam_q;
  gf_t delta;
  logic signed [3:0] k_q;
  logic it_q;

  for (genvar gs = 0; gs < N_SYN; gs++) begin : g_unpack
    assign syn_w[gs] = syn_i[gs*GF_M +: GF_M];
  end

  // discrepancy: coefficient of x^(2r) in S(x)*lambda(x)
  always_comb begin
    delta = '0;
    for (int j = 0; j < LOC_TERMS; j++) begin
      int sidx;
      sidx = 2 * int'(it_q) + 1 - j;
      if (sidx >= 1) delta = delta ^ gf_mul(lam_q[j], syn_w[sidx-1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clear) begin
      lam_q[0] <= gf_t'(1);
      lam_q[1] <= '0;
      lam_q[2] <= '0;
      bb_q[0]  <= gf_t'(1);
      bb_q[1]  <= '0;
      gam_q    <= gf_t'(1);
      k_q      <= '0;
      it_q     <= 1'b0;
    end else if (step) begin
      lam_q[0] <= gf_mul(gam_q, lam_q[0]);
      for (int j = 1; j < LOC_TERMS; j++)
        lam_q[j] <= gf_mul(gam_q, lam_q[j]) ^ gf_mul(delta, bb_q[j-1]);
      if (delta != '0 && k_q >= 0) begin
        bb_q[0] <= '0;
        bb_q[1] <= lam_q[0];
        gam_q   <= delta;
        k_q     <= -k_q;
      end else begin
        bb_q[0] <= '0;
        bb_q[1] <= '0;
        k_q     <= k_q + 4'sd2;
      end
      it_q <= ~it_q;
    end
  end

  assign lam0_o = lam_q[0];
  assign lam1_o = lam_q[1];
  assign lam2_o = lam_q[2];

  AST_LAM0_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) lam_q[0] != '0); // R6
endmodule

// File: rtl/bch_chien.sv
`timescale 1ns/1ps
module bch_chien
  import bch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              first,
  input  gf_t               lam0,
  input  gf_t               lam1,
  input  gf_t               lam2,
  output logic [BYTE_W-1:0] hit
);
  localparam int TOP_BASE = (N_BEATS - 1) * BYTE_W;
  localparam gf_t INIT1 = gf_pow(GF_N - TOP_BASE);
  localparam gf_t INIT2 = gf_pow(2 * GF_N - 2 * TOP_BASE);
  localparam gf_t STEP1 = gf_pow(BYTE_W);
  localparam gf_t STEP2 = gf_pow(2 * BYTE_W);

  gf_t c1_q, c2_q, cur1, cur2;

  assign cur1 = first ? gf_mul(lam1, INIT1) : c1_q;
  assign cur2 = first ? gf_mul(lam2, INIT2) : c2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q <= '0;
      c2_q <= '0;
    end else if (run) begin
      c1_q <= gf_mul(cur1, STEP1);
      c2_q <= gf_mul(cur2, STEP2);
    end
  end

  // lane k tests position base+k by evaluating lambda at alpha^-(base+k)
  for (genvar gk = 0; gk < BYTE_W; gk++) begin : g_lane
    localparam gf_t OFS1 = gf_pow(GF_N - gk);
    localparam gf_t OFS2 = gf_pow(2 * GF_N - 2 * gk);
    gf_t val;
    assign val     = lam0 ^ gf_mul(cur1, OFS1) ^ gf_mul(cur2, OFS2);
    assign hit[gk] = (val == '0);
  end

  AST_ROOTS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) run |-> $countones(hit) <= 2); // R5
endmodule

// File: rtl/bch_dec63.sv
`timescale 1ns/1ps
module bch_dec63
  import bch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [50:0]       out_data,
  output logic              out_corrected,
  output logic              out_uncorrectable
);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(N_BEATS - 1);
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(N_ITER - 1);
  localparam int SHIFT_W = GF_N - BYTE_W;

  dec_state_e state;
  logic [CNT_W-1:0] cnt;
  logic [GF_N-1:0] rx_q, err_q, fixed;
  logic [N_SYN*GF_M-1:0] syn;
  logic [BYTE_W-1:0] syn_byte, hit;
  logic accept, first_beat, syn_nz;
  gf_t lam0, lam1, lam2;
  int nroot, deg;
  logic [DATA_W-1:0] od_q;
  logic oc_q, ou_q;

  assign in_ready   = (state == ST_LOAD) || (state == ST_OUT && out_ready);
  assign accept     = in_valid && in_ready;
  assign first_beat = (state == ST_OUT) || (cnt == '0);
  // the padding position never enters the syndromes
  assign syn_byte   = first_beat ? {1'b0, in_data[BYTE_W-2:0]} : in_data;

  bch_syndrome u_syn (
    .clk(clk), .rst_n(rst_n), .beat(accept), .first(first_beat),
    .byte_in(syn_byte), .syn_o(syn)
  );

  bch_locator u_loc (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_LOAD), .step(state == ST_KEY),
    .syn_i(syn), .lam0_o(lam0), .lam1_o(lam1), .lam2_o(lam2)
  );

  bch_chien u_chien (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SRCH), .first(cnt == '0),
    .lam0(lam0), .lam1(lam1), .lam2(lam2), .hit(hit)
  );

  assign syn_nz = |syn;
  assign fixed  = rx_q ^ err_q;
  assign nroot  = $countones(err_q);
  assign deg    = (lam2 != '0) ? 2 : ((lam1 != '0) ? 1 : 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOAD;
      cnt   <= '0;
      rx_q  <= '0;
      err_q <= '0;
      od_q  <= '0;
      oc_q  <= 1'b0;
      ou_q  <= 1'b0;
    end else begin
      if (accept)            rx_q  <= {rx_q[SHIFT_W-1:0], in_data};
      if (state == ST_SRCH)  err_q <= {err_q[SHIFT_W-1:0], hit};
      case (state)
        ST_LOAD: if (accept) begin
          if (cnt == LAST_BEAT) begin cnt <= '0; state <= ST_KEY; end
          else cnt <= cnt + 1'b1;
        end
        ST_KEY: begin
          if (cnt == LAST_ITER) begin cnt <= '0; state <= ST_SRCH; end
          else cnt <= cnt + 1'b1;
        end
        ST_SRCH: begin
          if (cnt == LAST_BEAT) begin cnt <= '0; state <= ST_FIN; end
          else cnt <= cnt + 1'b1;
        end
        ST_FIN: begin
          state <= ST_OUT;
          if (!syn_nz) begin
            od_q <= rx_q[GF_N-1:PAR_W]; oc_q <= 1'b0; ou_q <= 1'b0;
          end else if (deg == 0 || nroot != deg) begin
            od_q <= rx_q[GF_N-1:PAR_W]; oc_q <= 1'b0; ou_q <= 1'b1;
          end else begin
            od_q <= fixed[GF_N-1:PAR_W]; oc_q <= 1'b1; ou_q <= 1'b0;
          end
        end
        ST_OUT: if (out_ready) begin
          state <= ST_LOAD;
          cnt   <= accept ? CNT_W'(1) : '0;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  assign out_valid         = (state == ST_OUT);
  assign out_data          = od_q;
  assign out_corrected     = oc_q;
  assign out_uncorrectable = ou_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_corrected) && $stable(out_uncorrectable)); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(out_corrected && out_uncorrectable)); // R7
  AST_UNCORR_RAW: assert property (@(posedge clk) disable iff (!rst_n) out_valid && out_uncorrectable |-> out_data == rx_q[GF_N-1:PAR_W]); // R6
  AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_KEY || state == ST_SRCH) |-> !accept); // R9
endmodule

// File: tb/bch_dec63_bench.sv
`timescale 1ns/1ps
module bch_dec63_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid, in_ready, out_valid, out_ready, out_corrected, out_uncorrectable;
  logic [7:0] in_data;
  logic [50:0] out_data;

  int n_vec = 0;
  int n_bad = 0;
  localparam int NW = 300;
  localparam int N_DIR = 10;

  logic [5:0] pw [63];
  int lg [64];

  always #2 clk = ~clk;

  bch_dec63 u_bch_dec63 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_corrected(out_corrected), .out_uncorrectable(out_uncorrectable)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] parity(input logic [50:0] m);
    logic [11:0] rem;
    logic fb;
    rem = '0;
    for (int i = 50; i >= 0; i--) begin
      fb  = m[i] ^ rem[11];
      rem = {rem[10:0], 1'b0} ^ (fb ? 12'h539 : 12'h000);
    end
    return rem;
  endfunction

  // reference: search every pattern of one or two errors matching S1 and S3
  task automatic ref_decode(input logic [62:0] r, output logic [50:0] d,
                            output bit c, output bit u);
    logic [5:0] s1, s3;
    logic [62:0] e;
    bit found;
    s1 = '0; s3 = '0; e = '0; found = 0;
    for (int p = 0; p < 63; p++)
      if (r[p]) begin s1 ^= pw[p]; s3 ^= pw[(3*p) % 63]; end
    if (s1 == 0 && s3 == 0) begin
      d = r[62:12]; c = 0; u = 0;
      return;
    end
    for (int a = 0; a < 63 && !found; a++)
      if (pw[a] == s1 && pw[(3*a) % 63] == s3) begin e[a] = 1'b1; found = 1; end
    for (int a = 0; a < 63 && !found; a++)
      for (int b = a + 1; b < 63 && !found; b++)
        if ((pw[a] ^ pw[b]) == s1 && (pw[(3*a) % 63] ^ pw[(3*b) % 63]) == s3) begin
          e[a] = 1'b1; e[b] = 1'b1; found = 1;
        end
    if (found) begin d = (r ^ e) >> 12; c = 1; u = 0; end
    else       begin d = r[62:12];      c = 0; u = 1; end
  endtask

  task automatic gen_word(input int idx, output logic [63:0] w, output logic [50:0] ed,
                          output bit ec, output bit eu, output string tag);
    logic [50:0] m;
    logic [62:0] err, cw;
    logic pad;
    int wt;
    m   = {$urandom(), $urandom()};
    err = '0; pad = 1'b0; wt = 0;
    case (idx)
      0: begin m = '0; tag = "R3 zero word"; end
      1: begin m = '1; tag = "R3 ones word"; end
      2: begin pad = 1'b1; tag = "R1 pad flip only"; end
      3: begin err[0] = 1'b1; wt = 1; tag = "R4 error at 0"; end
      4: begin err[62] = 1'b1; wt = 1; tag = "R4 error at 62"; end
      5: begin err[12] = 1'b1; wt = 1; tag = "R4 error at 12"; end
      6: begin err[0] = 1'b1; err[62] = 1'b1; wt = 2; tag = "R5 errors 0,62"; end
      7: begin err[30] = 1'b1; err[31] = 1'b1; wt = 2; tag = "R5 adjacent errors"; end
      8: begin err[1] = 1'b1; err[2] = 1'b1; err[3] = 1'b1; wt = 3; tag = "R6 triple error"; end
      9: begin err[5] = 1'b1; err[40] = 1'b1; pad = 1'b1; wt = 2; tag = "R1 pad with R5 pair"; end
      default: begin
        wt  = $urandom_range(0, 4);
        pad = 1'($urandom_range(0, 1));
        for (int k = 0; k < wt; k++) begin
          int p;
          do p = $urandom_range(0, 62); while (err[p]);
          err[p] = 1'b1;
        end
        tag = (wt > 2) ? "R2 R6 random" : "R2 random";
      end
    endcase
    cw = {m, parity(m)} ^ err;
    w  = {pad, cw};
    if (wt <= 2) begin ed = m; ec = (wt > 0); eu = 0; end
    else ref_decode(cw, ed, ec, eu);
  endtask

  task automatic send_from(input logic [63:0] w, input int start);
    for (int b = start; b < 8; b++) begin
      int gap;
      gap = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2) : 0;
      repeat (gap) begin @(negedge clk); in_valid = 1'b0; end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w[63-8*b -: 8];
      #0.1;
      while (!in_ready) begin @(negedge clk); #0.1; end
      @(posedge clk);
    end
  endtask

  task automatic collect(input logic [50:0] ed, input bit ec, input bit eu, input string tag,
                         input bit ovl, input logic [63:0] nw);
    int n;
    int stall;
    bit busy_ok;
    bit hold_ok;
    logic [52:0] snap;
    n = 0; busy_ok = 1; hold_ok = 1;
    do begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b0;
      #0.1;
      n++;
      if (!out_valid && in_ready) busy_ok = 0;
    end while (!out_valid && n < 40);
    chk(n == 12, "R10", "edges to result", 64'(n - 1), 64'd11);
    chk(busy_ok, "R9", "in_ready low while busy", 64'(busy_ok), 64'd1);
    snap  = {out_data, out_corrected, out_uncorrectable};
    stall = $urandom_range(0, 3);
    repeat (stall) begin
      @(negedge clk); #0.1;
      if (!out_valid || {out_data, out_corrected, out_uncorrectable} != snap) hold_ok = 0;
    end
    if (stall > 0) chk(hold_ok, "R8", "result held under stall", 64'(hold_ok), 64'd1);
    chk({out_data, out_corrected, out_uncorrectable} == {ed, ec, eu}, tag, "data/corr/uncorr",
        64'({out_data, out_corrected, out_uncorrectable}), 64'({ed, ec, eu}));
    chk(!(out_corrected && out_uncorrectable), "R7", "flag exclusivity",
        64'({out_corrected, out_uncorrectable}), 64'd0);
    out_ready = 1'b1;
    if (ovl) begin
      in_valid = 1'b1;
      in_data  = nw[63:56];
    end
    #0.1;
    if (ovl) chk(in_ready, "R9", "in_ready at result handoff", 64'(in_ready), 64'd1);
    @(posedge clk);
  endtask

  initial begin
    logic [63:0] w, nw;
    logic [50:0] ed, ned;
    bit ec, eu, nec, neu, ovl, last;
    string tag, ntag;
    void'($urandom(32'd20240611));
    pw[0] = 6'd1;
    lg[0] = 0;
    lg[1] = 0;
    for (int i = 1; i < 63; i++) begin
      logic [6:0] v;
      v = {pw[i-1], 1'b0};
      if (v[6]) v = v ^ 7'b1000011;
      pw[i] = v[5:0];
      lg[v[5:0]] = i;
    end
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    nw = '0; ned = '0; nec = 0; neu = 0; ntag = "";
    repeat (3) @(negedge clk);
    #0.1;
    chk(!out_valid && in_ready, "R9", "reset state valid/ready",
        64'({out_valid, in_ready}), 64'b01);
    rst_n = 1'b1;
    gen_word(0, w, ed, ec, eu, tag);
    send_from(w, 0);
    for (int i = 0; i < NW; i++) begin
      last = (i == NW - 1);
      if (!last) gen_word(i + 1, nw, ned, nec, neu, ntag);
      ovl = !last && ((i % 2 == 1) || ($urandom_range(0, 1) == 1));
      collect(ed, ec, eu, tag, ovl, nw);
      if (!last) begin
        send_from(nw, ovl ? 1 : 0);
        w = nw; ed = ned; ec = nec; eu = neu; tag = ntag;
      end
    end
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R10 watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule